// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational binary adder for two 16-bit operands and an incoming carry. It is built as a hierarchy. Each bit position forms a generate term (both operand bits set) and an OR-style propagate term (either bit set). Four-bit slices turn those terms into their internal carries with flattened sum-of-products equations. Each slice also reports one slice-generate and one slice-propagate. A second lookahead stage applies the same flattened equations to the slice terms. From them it forms the carry entering every slice and the final carry-out, so no carry ever ripples from slice to slice.

A subtract control turns the block into a subtractor. When it is set, the second operand is inverted and the incoming carry is forced high, which adds the two's-complement negation of that operand. The block reports signed overflow under the rule that belongs to the selected operation. It also exposes the whole-word generate and propagate, so that a third lookahead level outside the block can treat it as one large slice.

Top module: `lookahead_adder`

## Requirements
- R1: With `sub` low, `sum` equals `(op_a + op_b + carry_in) mod 2^16`.
- R2: `carry_out` equals bit 16 of the 17-bit total of the effective operands and the effective carry-in. The effective second operand is `op_b` when adding and `~op_b` when subtracting. The effective carry-in is `carry_in` when adding and 1 when subtracting.
- R3: With `sub` high, `sum` equals `(op_a - op_b) mod 2^16` and `carry_out` is 1 exactly when `op_a >= op_b` as unsigned numbers. The value of `carry_in` has no effect on any output.
- R4: `grp_gen` is 1 exactly when the effective operands alone, with no incoming carry, produce a carry out of bit 15.
- R5: `grp_prop` is 1 exactly when every bit position has at least one effective operand bit set, i.e. `&(op_a | b_eff)`.
- R6: `carry_out` always equals `grp_gen | (grp_prop & c_eff)`, where `c_eff` is the effective carry-in.
- R7: With `sub` low, `overflow` is 1 exactly when `op_a[15]` equals `op_b[15]` and `sum[15]` differs from them.
- R8: With `sub` high, `overflow` is 1 exactly when `op_a[15]` differs from `op_b[15]` and `sum[15]` differs from `op_a[15]`.
- R9: A carry produced in the lowest slice reaches the carry-out through all higher slices. For example, `0xFFFF + 0x0000` with `carry_in` 1 gives `sum` 0 and `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (minuend when subtracting) |
| op_b | input | 16 | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Incoming carry, used only when adding |
| sub | input | 1 | 1 selects subtraction, 0 selects addition |
| sum | output | 16 | Result word |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen | output | 1 | Whole-word generate for a further lookahead level |
| grp_prop | output | 1 | Whole-word propagate (AND of the OR-style bit propagates) |
| overflow | output | 1 | Signed overflow for the selected operation |

## Verification
The hardest case to reach is a carry that starts in the lowest slice and crosses every higher slice on propagate terms alone. A second hard case is a bit where generate and OR-propagate are both true, which the OR definition allows and an XOR definition would not. Uniform random operands seldom produce a long run of propagating slices. The stimulus therefore crosses a set of structured words with one another under both operations and both carry-in values: all-ones, zero, the most-negative value, the largest positive value, single-slice masks, alternating bits and walking ones. A long random run then follows.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

    localparam int LA_MAX = 16;

    typedef logic [LA_MAX-1:0] la_vec_t;

    // Carry into position pos, as a flattened sum of products:
    // c0 & p[0..pos-1]  |  OR over j<pos of ( g[j] & p[j+1..pos-1] )
    function automatic logic la_carry(input la_vec_t g, input la_vec_t p,
                                      input logic c0, input int pos);
        logic acc;
        logic term;
        acc = c0;
        for (int k = 0; k < LA_MAX; k++) begin
            if (k < pos) acc = acc & p[k];
        end
        for (int j = 0; j < LA_MAX; j++) begin
            if (j < pos) begin
                term = g[j];
                for (int k = 0; k < LA_MAX; k++) begin
                    if (k > j && k < pos) term = term & p[k];
                end
                acc = acc | term;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/la_bit_terms.sv
module la_bit_terms (
    input  logic a_i,
    input  logic b_i,
    output logic gen_o,
    output logic prop_o,
    output logic half_o
);
    always_comb begin
        gen_o  = a_i & b_i;
        prop_o = a_i | b_i;
        half_o = a_i ^ b_i;
    end
endmodule

// File: rtl/la_slice.sv
module la_slice
    import lookahead_pkg::*;
#(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] gen_i,
    input  logic [SLICE-1:0] prop_i,
    input  logic [SLICE-1:0] half_i,
    input  logic             cin_i,
    output logic [SLICE-1:0] sum_o,
    output logic             sgen_o,
    output logic             sprop_o
);
    la_vec_t          gen_pad;
    la_vec_t          prop_pad;
    logic [SLICE-1:0] carry_d;

    always_comb begin
        gen_pad               = '0;
        prop_pad              = '0;
        gen_pad[SLICE-1:0]    = gen_i;
        prop_pad[SLICE-1:0]   = prop_i;
        for (int i = 0; i < SLICE; i++) begin
            carry_d[i] = la_carry(gen_pad, prop_pad, cin_i, i);
        end
        sum_o   = half_i ^ carry_d;
        sgen_o  = la_carry(gen_pad, prop_pad, 1'b0, SLICE);
        sprop_o = &prop_i;
    end
endmodule

// File: rtl/la_upper.sv
module la_upper
    import lookahead_pkg::*;
#(
    parameter int NSLICE = 4
) (
    input  logic [NSLICE-1:0] sgen_i,
    input  logic [NSLICE-1:0] sprop_i,
    input  logic              c0_i,
    output logic [NSLICE-1:0] scarry_o,
    output logic              cout_o,
    output logic              wgen_o,
    output logic              wprop_o
);
    la_vec_t gen_pad;
    la_vec_t prop_pad;

    always_comb begin
        gen_pad              = '0;
        prop_pad             = '0;
        gen_pad[NSLICE-1:0]  = sgen_i;
        prop_pad[NSLICE-1:0] = sprop_i;
        for (int i = 0; i < NSLICE; i++) begin
            scarry_o[i] = la_carry(gen_pad, prop_pad, c0_i, i);
        end
        cout_o  = la_carry(gen_pad, prop_pad, c0_i, NSLICE);
        wgen_o  = la_carry(gen_pad, prop_pad, 1'b0, NSLICE);
        wprop_o = &sprop_i;
    end
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
    parameter int WIDTH = 16,
    parameter int SLICE = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             grp_gen,
    output logic             grp_prop,
    output logic             overflow
);
    localparam int NSLICE = WIDTH / SLICE;

    logic [WIDTH-1:0]  b_eff_d;
    logic              c0_d;
    logic [WIDTH-1:0]  gen_w;
    logic [WIDTH-1:0]  prop_w;
    logic [WIDTH-1:0]  half_w;
    logic [NSLICE-1:0] sgen_w;
    logic [NSLICE-1:0] sprop_w;
    logic [NSLICE-1:0] scarry_w;

    always_comb begin
        b_eff_d = sub ? ~op_b : op_b;
        c0_d    = sub | carry_in;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        la_bit_terms u_bit (
            .a_i    (op_a[i]),
            .b_i    (b_eff_d[i]),
            .gen_o  (gen_w[i]),
            .prop_o (prop_w[i]),
            .half_o (half_w[i])
        );
    end

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        la_slice #(.SLICE(SLICE)) u_slice (
            .gen_i   (gen_w[s*SLICE +: SLICE]),
            .prop_i  (prop_w[s*SLICE +: SLICE]),
            .half_i  (half_w[s*SLICE +: SLICE]),
            .cin_i   (scarry_w[s]),
            .sum_o   (sum[s*SLICE +: SLICE]),
            .sgen_o  (sgen_w[s]),
            .sprop_o (sprop_w[s])
        );
    end

    la_upper #(.NSLICE(NSLICE)) u_upper (
        .sgen_i   (sgen_w),
        .sprop_i  (sprop_w),
        .c0_i     (c0_d),
        .scarry_o (scarry_w),
        .cout_o   (carry_out),
        .wgen_o   (grp_gen),
        .wprop_o  (grp_prop)
    );

    always_comb begin
        if (sub)
            overflow = (op_a[WIDTH-1] != op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1]);
        else
            overflow = (op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1]);
    end
endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic             sub,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             grp_gen,
    input logic             grp_prop,
    input logic             overflow
);
    logic [WIDTH-1:0] b_ref;
    logic             c_ref;
    logic [WIDTH:0]   tot_ref;
    logic [WIDTH:0]   raw_ref;

    always_comb begin
        b_ref   = sub ? ~op_b : op_b;
        c_ref   = sub ? 1'b1 : carry_in;
        tot_ref = {1'b0, op_a} + {1'b0, b_ref} + {{WIDTH{1'b0}}, c_ref};
        raw_ref = {1'b0, op_a} + {1'b0, b_ref};

        AST_SUM_ARITH: assert (sub || sum == tot_ref[WIDTH-1:0]) else $error("sum mismatch"); // R1
        AST_CARRY_OUT: assert (carry_out == tot_ref[WIDTH]) else $error("carry-out mismatch"); // R2
        AST_SUB_RESULT: assert (!sub || sum == op_a - op_b) else $error("difference mismatch"); // R3
        AST_WORD_GEN: assert (grp_gen == raw_ref[WIDTH]) else $error("word generate mismatch"); // R4
        AST_WORD_PROP: assert (grp_prop == &(op_a | b_ref)) else $error("word propagate mismatch"); // R5
        AST_CARRY_COMPOSE: assert (carry_out == (grp_gen | (grp_prop & c_ref))) else $error("carry compose"); // R6
        AST_NO_OVERFLOW_ADD: assert (sub || op_a[WIDTH-1] == op_b[WIDTH-1] || !overflow) else $error("add ovf"); // R7
        AST_NO_OVERFLOW_SUB: assert (!sub || op_a[WIDTH-1] != op_b[WIDTH-1] || !overflow) else $error("sub ovf"); // R8
    end
endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sub       (sub),
    .sum       (sum),
    .carry_out (carry_out),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .overflow  (overflow)
);

// File: tb/tb_lookahead_adder.sv
`timescale 1ns/1ps
module tb_lookahead_adder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         sub = 1'b0;
    logic [W-1:0] sum;
    logic         carry_out;
    logic         grp_gen;
    logic         grp_prop;
    logic         overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    lookahead_adder dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sub(sub),
        .sum(sum), .carry_out(carry_out), .grp_gen(grp_gen),
        .grp_prop(grp_prop), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%0b sub=%0b actual=%h expected=%h",
                     req, op_a, op_b, carry_in, sub, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input logic s);
        logic [W-1:0] be;
        logic         ce;
        logic [W:0]   tot;
        logic [W:0]   raw;
        logic         ovf;
        @(posedge clk);
        op_a = a; op_b = b; carry_in = ci; sub = s;
        @(negedge clk);
        be  = s ? ~b : b;
        ce  = s ? 1'b1 : ci;
        tot = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, ce};
        raw = {1'b0, a} + {1'b0, be};
        if (s) begin
            ovf = (a[W-1] != b[W-1]) && (tot[W-1] != a[W-1]);
            chk("R3 difference", {16'h0, sum}, {16'h0, a - b});
            chk("R3 no-borrow", {31'h0, carry_out}, {31'h0, (a >= b)});
            chk("R8 sub overflow", {31'h0, overflow}, {31'h0, ovf});
        end else begin
            ovf = (a[W-1] == b[W-1]) && (tot[W-1] != a[W-1]);
            chk("R1 sum", {16'h0, sum}, {16'h0, tot[W-1:0]});
            chk("R2 carry-out", {31'h0, carry_out}, {31'h0, tot[W]});
            chk("R7 add overflow", {31'h0, overflow}, {31'h0, ovf});
        end
        chk("R4 word generate", {31'h0, grp_gen}, {31'h0, raw[W]});
        chk("R5 word propagate", {31'h0, grp_prop}, {31'h0, &(a | be)});
        chk("R6 carry compose", {31'h0, carry_out}, {31'h0, raw[W] | (&(a | be) & ce)});
    endtask

    function automatic logic [W-1:0] pattern(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h7FFF;
            4: return 16'h0001;
            5: return 16'h000F;
            6: return 16'h00F0;
            7: return 16'h0F00;
            8: return 16'hF000;
            9: return 16'hAAAA;
            10: return 16'h5555;
            11: return 16'h8001;
            default: return 16'h7FF0;
        endcase
    endfunction

    initial begin
        #(20 * 190000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s0;
        logic         c0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: all inputs at zero
        chk("R1 reset sum", {16'h0, sum}, 32'h0);
        chk("R2 reset carry", {31'h0, carry_out}, 32'h0);
        chk("R5 reset propagate", {31'h0, grp_prop}, 32'h0);
        rst_n = 1'b1;

        // R9: carry born in lowest slice crosses every slice
        apply(16'hFFFF, 16'h0000, 1'b1, 1'b0);
        chk("R9 long carry sum", {16'h0, sum}, 32'h0);
        chk("R9 long carry out", {31'h0, carry_out}, 32'h1);
        apply(16'hFFF0, 16'h0010, 1'b0, 1'b0);
        chk("R9 carry from slice1", {16'h0, sum}, 32'h0);
        // generate and OR-propagate both true at every bit
        apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        chk("R5 prop with gen", {31'h0, grp_prop}, 32'h1);
        chk("R4 gen all ones", {31'h0, grp_gen}, 32'h1);
        // most-negative overflow cases
        apply(16'h8000, 16'h8000, 1'b0, 1'b0);
        chk("R7 neg+neg overflow", {31'h0, overflow}, 32'h1);
        apply(16'h0000, 16'h8000, 1'b0, 1'b1);
        chk("R8 0-min overflow", {31'h0, overflow}, 32'h1);
        apply(16'h7FFF, 16'h0001, 1'b0, 1'b0);
        chk("R7 max+1 overflow", {31'h0, overflow}, 32'h1);

        // R3: carry_in has no effect while subtracting
        apply(16'h1234, 16'h0FFF, 1'b0, 1'b1);
        s0 = sum; c0 = carry_out;
        apply(16'h1234, 16'h0FFF, 1'b1, 1'b1);
        chk("R3 cin ignored sum", {16'h0, sum}, {16'h0, s0});
        chk("R3 cin ignored carry", {31'h0, carry_out}, {31'h0, c0});

        // structured cross sweep
        for (int i = 0; i < 13; i++)
            for (int j = 0; j < 13; j++)
                for (int m = 0; m < 4; m++)
                    apply(pattern(i), pattern(j), m[0], m[1]);

        // walking ones against all-ones and zero
        for (int i = 0; i < W; i++) begin
            apply(16'(1 << i), 16'hFFFF, 1'b0, 1'b0);
            apply(16'hFFFF, 16'(1 << i), 1'b1, 1'b0);
            apply(16'(1 << i), 16'h0000, 1'b0, 1'b1);
            apply(16'h0000, 16'(1 << i), 1'b1, 1'b1);
        end

        // random operands
        for (int n = 0; n < 40000; n++)
            apply(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule